// File: doc/BRIEF.md
# String Instruction Restart Fixup Unit

When a string instruction is interrupted by a fault, its source pointer, destination pointer and count may not match the state that a restart needs. This unit takes the saved SI, DI and CX and returns the values the fault handler writes back before it re-executes the instruction. The caller also gives the instruction kind, the direction flag, the element size, whether a repeat prefix was present and, for input strings, whether the fault was the privilege check on the first port read.

Store, input, scan and output strings adjust one pointer and return in a single step. Moves and compares adjust their first pointer and then ask an external checker, over a probe port, whether the updated address would fault. A move probes the source. A compare probes the destination. If the checker reports no fault, the second pointer receives the same step and the count is raised once more. A single-cycle done pulse marks the result. The results then hold until the next start.

Top module: `strfix_unit`

## Requirements
- R1: The pointer step has magnitude 1 when `word_i`=0 and 2 when `word_i`=1. It is added when `df_i`=0 and subtracted when `df_i`=1.
- R2: Kind code 0 (store string) returns DI plus one step and SI unchanged. CX rises by 2 if `rep_i`=1. Done is asserted in the cycle after the start.
- R3: Kind code 1 (input string) returns DI plus one step and SI unchanged. With `rep_i`=1, CX rises by 1 when `ins_priv_i`=1 and by 2 when `ins_priv_i`=0.
- R4: Kind codes 2 (scan string) and 3 (output string) return SI plus one step and DI unchanged. CX rises by 2 if `rep_i`=1.
- R5: Kind code 4 (move string) raises `probe_valid_o` with `probe_addr_o` set to SI plus one step and `probe_sel_o`=0.
  - If the checker answers no fault, DI also gets the step and CX rises by 2 when `rep_i`=1.
  - If the checker answers fault, DI is unchanged and CX rises by 1 when `rep_i`=1.
- R6: Kind code 5 (compare string) raises `probe_valid_o` with `probe_addr_o` set to DI plus one step and `probe_sel_o`=1.
  - If the checker answers no fault, SI also gets the step and CX rises by 2 when `rep_i`=1.
  - If the checker answers fault, SI is unchanged and CX rises by 1 when `rep_i`=1.
- R7: All pointer and count arithmetic wraps modulo 2^16.
- R8: `probe_valid_o` and `probe_addr_o` hold until `probe_ready_i` is sampled high. The response (`probe_resp_valid_i`, `probe_fault_i`) is taken only after that. Done is asserted in the cycle after the response.
- R9: A start that arrives while a probe is outstanding is ignored.
- R10: `done_o` is a single-cycle pulse. With no new start, `si_o`, `di_o` and `cx_o` hold their values.
- R11: After reset, `done_o` and `probe_valid_o` are 0 and `si_o`, `di_o` and `cx_o` are 0.
- R12: Kind codes 6 and 7 return SI, DI and CX unchanged, with done in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe |
| kind_i | input | 3 | Instruction kind code |
| df_i | input | 1 | Direction flag |
| word_i | input | 1 | Element size, 1 = word |
| rep_i | input | 1 | Repeat prefix present |
| ins_priv_i | input | 1 | Input-string fault came from the first-read privilege check |
| si_i | input | 16 | Saved SI |
| di_i | input | 16 | Saved DI |
| cx_i | input | 16 | Saved CX |
| probe_valid_o | output | 1 | Probe request valid |
| probe_ready_i | input | 1 | Probe request accepted |
| probe_addr_o | output | 16 | Offset to be checked |
| probe_sel_o | output | 1 | 0 = source operand, 1 = destination operand |
| probe_resp_valid_i | input | 1 | Probe answer valid |
| probe_fault_i | input | 1 | Probed address would fault |
| si_o | output | 16 | Corrected SI |
| di_o | output | 16 | Corrected DI |
| cx_o | output | 16 | Corrected CX |
| done_o | output | 1 | Result valid pulse |

## Verification
The bench drives moves and compares through both probe answers. A design that mixed up which pointer is probed, or that raised the count by the wrong amount, would return DI, SI or CX off by one step. Input strings are run with the privilege cause both set and clear, which exposes a design that always adds 2. Pointers at 0xFFFF and 0x0000 catch missing wrap. A start issued during an outstanding probe, and a ready held low, catch a design that restarts mid-operation or lets its probe address drift.

// File: rtl/strfix_pkg.sv
package strfix_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        K_STOS = 3'd0,
        K_INS  = 3'd1,
        K_SCAS = 3'd2,
        K_OUTS = 3'd3,
        K_MOVS = 3'd4,
        K_CMPS = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2
    } state_e;
endpackage

// File: rtl/strfix_step.sv
module strfix_step #(
    parameter int W = 16
) (
    input  logic         df,
    input  logic         word,
    output logic [W-1:0] step
);
    logic [W-1:0] mag;

    always_comb begin
        mag  = word ? W'(2) : W'(1);
        step = df ? (~mag + W'(1)) : mag;
    end
endmodule

// File: rtl/strfix_cxadj.sv
module strfix_cxadj
    import strfix_pkg::*;
(
    input  logic [2:0] kind,
    input  logic       rep,
    input  logic       priv,
    input  logic       second_adj,
    output logic [1:0] inc
);
    always_comb begin
        inc = 2'd0;
        if (rep) begin
            case (kind)
                K_STOS, K_SCAS, K_OUTS: inc = 2'd2;
                K_INS:                  inc = priv ? 2'd1 : 2'd2;
                K_MOVS, K_CMPS:         inc = second_adj ? 2'd2 : 2'd1;
                default:                inc = 2'd0;
            endcase
        end
    end
endmodule

// File: rtl/strfix_unit.sv
module strfix_unit
    import strfix_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [2:0]   kind_i,
    input  logic         df_i,
    input  logic         word_i,
    input  logic         rep_i,
    input  logic         ins_priv_i,
    input  logic [W-1:0] si_i,
    input  logic [W-1:0] di_i,
    input  logic [W-1:0] cx_i,
    output logic         probe_valid_o,
    input  logic         probe_ready_i,
    output logic [W-1:0] probe_addr_o,
    output logic         probe_sel_o,
    input  logic         probe_resp_valid_i,
    input  logic         probe_fault_i,
    output logic [W-1:0] si_o,
    output logic [W-1:0] di_o,
    output logic [W-1:0] cx_o,
    output logic         done_o
);
    typedef struct packed {
        state_e       st;
        logic [2:0]   kind;
        logic         df;
        logic         word;
        logic         rep;
        logic [W-1:0] si;
        logic [W-1:0] di;
        logic [W-1:0] cx;
        logic [W-1:0] cx0;
        logic         done;
    } regs_t;

    regs_t q, d;

    logic         idle;
    logic [W-1:0] step;
    logic [1:0]   cx_inc;
    logic [2:0]   op_kind;

    assign idle    = (q.st == S_IDLE);
    assign op_kind = idle ? kind_i : q.kind;

    strfix_step #(.W(W)) u_step (
        .df   (idle ? df_i   : q.df),
        .word (idle ? word_i : q.word),
        .step (step)
    );

    strfix_cxadj u_cxadj (
        .kind       (op_kind),
        .rep        (idle ? rep_i : q.rep),
        .priv       (ins_priv_i),
        .second_adj ((q.st == S_WAIT) && !probe_fault_i),
        .inc        (cx_inc)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.kind = kind_i;
                    d.df   = df_i;
                    d.word = word_i;
                    d.rep  = rep_i;
                    d.cx0  = cx_i;
                    d.si   = si_i;
                    d.di   = di_i;
                    d.cx   = cx_i + W'(cx_inc);
                    d.done = 1'b1;
                    case (kind_i)
                        K_STOS, K_INS:  d.di = di_i + step;
                        K_SCAS, K_OUTS: d.si = si_i + step;
                        K_MOVS: begin
                            d.si   = si_i + step;
                            d.cx   = cx_i;
                            d.done = 1'b0;
                            d.st   = S_REQ;
                        end
                        K_CMPS: begin
                            d.di   = di_i + step;
                            d.cx   = cx_i;
                            d.done = 1'b0;
                            d.st   = S_REQ;
                        end
                        default: ;
                    endcase
                end
            end
            S_REQ: begin
                if (probe_ready_i) d.st = S_WAIT;
            end
            S_WAIT: begin
                if (probe_resp_valid_i) begin
                    if (!probe_fault_i) begin
                        if (q.kind == K_MOVS) d.di = q.di + step;
                        else                  d.si = q.si + step;
                    end
                    d.cx   = q.cx + W'(cx_inc);
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign probe_valid_o = (q.st == S_REQ);
    assign probe_sel_o   = (q.kind == K_CMPS);
    assign probe_addr_o  = probe_sel_o ? q.di : q.si;
    assign si_o          = q.si;
    assign di_o          = q.di;
    assign cx_o          = q.cx;
    assign done_o        = q.done;

    p_probe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid_o && !probe_ready_i) |=> (probe_valid_o && $stable(probe_addr_o)));

    p_done_no_probe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !probe_valid_o);

    p_busy_start_ign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid_o && start_i && !probe_ready_i) |=> (probe_valid_o && $stable(si_o) && $stable(di_o)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start_i) |=> ($stable(si_o) && $stable(di_o) && $stable(cx_o)));

    p_cx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((cx_o - q.cx0) <= W'(2)));
endmodule

// File: tb/strfix_unit_bench.sv
module strfix_unit_bench;
    typedef struct packed {
        logic [2:0]  kind;
        logic        df;
        logic        word;
        logic        rep;
        logic        priv;
        logic        fault;
        logic [15:0] si;
        logic [15:0] di;
        logic [15:0] cx;
        logic [15:0] esi;
        logic [15:0] edi;
        logic [15:0] ecx;
        logic [15:0] eaddr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h1000,16'h2000,16'd5,16'h1000,16'h2001,16'd7,16'h0},     // R2
        '{3'd0,1'b1,1'b1,1'b0,1'b0,1'b0,16'h1000,16'h2000,16'd5,16'h1000,16'h1FFE,16'd5,16'h0},     // R1 R2
        '{3'd1,1'b0,1'b1,1'b1,1'b1,1'b0,16'h1000,16'h2000,16'd5,16'h1000,16'h2002,16'd6,16'h0},     // R3
        '{3'd1,1'b1,1'b0,1'b1,1'b0,1'b0,16'h1000,16'h2000,16'd5,16'h1000,16'h1FFF,16'd7,16'h0},     // R3
        '{3'd2,1'b0,1'b1,1'b1,1'b0,1'b0,16'h1000,16'h2000,16'd5,16'h1002,16'h2000,16'd7,16'h0},     // R4
        '{3'd3,1'b1,1'b1,1'b0,1'b0,1'b0,16'h1000,16'h2000,16'd5,16'h0FFE,16'h2000,16'd5,16'h0},     // R4
        '{3'd4,1'b0,1'b1,1'b1,1'b0,1'b0,16'h1000,16'h2000,16'd5,16'h1002,16'h2002,16'd7,16'h1002},  // R5
        '{3'd4,1'b1,1'b0,1'b1,1'b0,1'b1,16'h1000,16'h2000,16'd5,16'h0FFF,16'h2000,16'd6,16'h0FFF},  // R5
        '{3'd5,1'b0,1'b0,1'b1,1'b0,1'b0,16'h1000,16'h2000,16'd5,16'h1001,16'h2001,16'd7,16'h2001},  // R6
        '{3'd5,1'b1,1'b1,1'b0,1'b0,1'b1,16'h1000,16'h2000,16'd5,16'h1000,16'h1FFE,16'd5,16'h1FFE},  // R6
        '{3'd0,1'b0,1'b1,1'b1,1'b0,1'b0,16'h1000,16'hFFFF,16'hFFFF,16'h1000,16'h0001,16'h0001,16'h0}, // R7
        '{3'd2,1'b1,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h2000,16'd5,16'hFFFE,16'h2000,16'd5,16'h0},     // R7
        '{3'd6,1'b0,1'b1,1'b1,1'b0,1'b0,16'h1234,16'h5678,16'd9,16'h1234,16'h5678,16'd9,16'h0},     // R12
        '{3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,16'h1000,16'h2000,16'd5,16'h1001,16'h2001,16'd5,16'h1001}   // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  kind_i = '0;
    logic        df_i = 1'b0, word_i = 1'b0, rep_i = 1'b0, ins_priv_i = 1'b0;
    logic [15:0] si_i = '0, di_i = '0, cx_i = '0;
    logic        probe_ready_i = 1'b0, probe_resp_valid_i = 1'b0, probe_fault_i = 1'b0;
    logic        probe_valid_o, probe_sel_o, done_o;
    logic [15:0] probe_addr_o, si_o, di_o, cx_o;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    strfix_unit u_strfix_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .df_i(df_i), .word_i(word_i), .rep_i(rep_i), .ins_priv_i(ins_priv_i),
        .si_i(si_i), .di_i(di_i), .cx_i(cx_i),
        .probe_valid_o(probe_valid_o), .probe_ready_i(probe_ready_i),
        .probe_addr_o(probe_addr_o), .probe_sel_o(probe_sel_o),
        .probe_resp_valid_i(probe_resp_valid_i), .probe_fault_i(probe_fault_i),
        .si_o(si_o), .di_o(di_o), .cx_o(cx_o), .done_o(done_o)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input string req, input bit poke_busy);
        @(negedge clk);
        kind_i = v.kind; df_i = v.df; word_i = v.word; rep_i = v.rep;
        ins_priv_i = v.priv; si_i = v.si; di_i = v.di; cx_i = v.cx;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (v.kind == 3'd4 || v.kind == 3'd5) begin
            chk(req, "probe_valid", {15'd0, probe_valid_o}, 16'd1);
            chk(req, "probe_addr", probe_addr_o, v.eaddr);
            chk(req, "probe_sel", {15'd0, probe_sel_o}, {15'd0, v.kind == 3'd5});
            chk("R8", "early done", {15'd0, done_o}, 16'd0);
            if (poke_busy) begin
                kind_i = 3'd0; si_i = 16'hAAAA; di_i = 16'h5555; cx_i = 16'd100;
                start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk("R8", "valid held", {15'd0, probe_valid_o}, 16'd1);
            chk("R8", "addr held", probe_addr_o, v.eaddr);
            probe_ready_i = 1'b1;
            @(negedge clk);
            probe_ready_i = 1'b0;
            chk("R8", "valid dropped", {15'd0, probe_valid_o}, 16'd0);
            chk("R8", "done before resp", {15'd0, done_o}, 16'd0);
            probe_resp_valid_i = 1'b1;
            probe_fault_i = v.fault;
            @(negedge clk);
            probe_resp_valid_i = 1'b0;
            probe_fault_i = 1'b0;
        end
        chk(req, "done", {15'd0, done_o}, 16'd1);
        chk(req, "si", si_o, v.esi);
        chk(req, "di", di_o, v.edi);
        chk(req, "cx", cx_o, v.ecx);
        @(negedge clk);
        chk("R10", "done pulse", {15'd0, done_o}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "done at reset", {15'd0, done_o}, 16'd0);
        chk("R11", "probe at reset", {15'd0, probe_valid_o}, 16'd0);
        chk("R11", "si at reset", si_o, 16'd0);
        chk("R11", "cx at reset", cx_o, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VEC[i], "vector", 1'b0);

        // R9: start during an outstanding probe is ignored
        run_vec(VEC[6], "R9", 1'b1);
        run_vec(VEC[9], "R9", 1'b1);

        // R10: outputs hold while idle
        repeat (4) @(negedge clk);
        chk("R10", "si hold", si_o, VEC[9].esi);
        chk("R10", "di hold", di_o, VEC[9].edi);
        chk("R10", "cx hold", cx_o, VEC[9].ecx);

        // R12: code 7 passes through
        run_vec('{3'd7,1'b1,1'b1,1'b1,1'b1,1'b0,16'h0042,16'h0043,16'd1,
                  16'h0042,16'h0043,16'd1,16'h0}, "R12", 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule